// File: doc/BRIEF.md
# Dynamic Bus Sizing Sequencer

This block turns one processor operand access into the series of external bus cycles needed to move it. A request gives the operand kind (byte, word, long word or a two-word instruction prefetch), a start address, a direction and, for writes, the operand data. The sequencer runs bus cycles until every operand byte has moved. In each cycle, the device that answers reports how wide its port is: 32, 16 or 8 bits. Each cycle moves only the bytes that fit between the current address and the next boundary of that port width. Because of this, a misaligned operand or a narrow port costs extra cycles.

On writes, the block places the operand bytes on the data lanes so that a port of any width finds the byte for the current address where it expects it. On reads, it collects the bytes returned by each cycle into one operand register. It then presents the finished operand with a single-cycle done pulse. Operands are big-endian: the byte at the lowest address is the most significant byte.

The request side uses valid/ready. `req_ready` is high only while no access is in progress. A request transfers on a clock edge where both `req_valid` and `req_ready` are high. A requester that sees `req_ready` low must hold its request until `req_ready` rises. The bus side and the done pulse are plain signals.

Top module: `dbs_sequencer`

## Requirements
- R1: `req_ready` is high exactly when no access is in progress. A request is taken only on an edge where `req_valid` and `req_ready` are both high, and `req_ready` is low in the cycle after it is taken.
- R2: Each bus cycle moves the smaller of two amounts: the bytes still outstanding, or the bytes from the current address to the next boundary of the reported port width. After each cycle, the next cycle's address is the old address plus the bytes moved.
- R3: A byte operand (kind code 0) takes exactly one bus cycle for every address offset and every port width.
- R4: A word operand (kind code 1) takes the following numbers of cycles on 32/16/8-bit ports. Offset 0: 1/1/2. Offset 1: 1/2/2. Offset 2: 1/1/2. Offset 3: 2/2/2.
- R5: A long-word operand (kind code 2) takes the following numbers of cycles on 32/16/8-bit ports. Offset 0: 1/2/4. Offset 1: 2/3/4. Offset 2: 2/2/4. Offset 3: 2/3/4.
- R6: An instruction prefetch (kind code 3) moves four bytes starting at the address with its two low bits forced to zero. It takes 1/2/4 cycles on 32/16/8-bit ports.
- R7: `cyc_size` gives the outstanding byte count modulo 4, so 1, 2 and 3 are encoded as themselves and 4 is encoded as 0.
- R8: `bus_ack` encodes the port width as 0 = 32 bits, 1 = 16 bits and 2 = 8 bits. The value 3 is a wait state: the cycle stays open with the same address and size, and no bytes count as moved.
- R9: On a write, the byte for the current address appears on the lanes that every port width uses. It is on lane `addr[1:0]` for a 32-bit port, on lane `addr[0]` of the upper half (bits 31:16) for a 16-bit port, and on bits 31:24 for an 8-bit port. Lane k is bits 31-8k down to 24-8k.
- R10: A read returns the operand right-justified in `done_rdata`, with the byte from the lowest address most significant and all bits above the operand zero.
- R11: `done_valid` is high for exactly one cycle per request, in the cycle after the final bus cycle is acknowledged.
- R12: A write stores only the low N bytes of `req_wdata` (N = 1, 2 or 4 by kind), with the most significant of them at the lowest address. Bytes outside the operand are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_kind | input | 2 | 0 byte, 1 word, 2 long word, 3 prefetch |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | ADDR_W | Operand start address |
| req_wdata | input | 32 | Write operand, right-justified |
| cyc_valid | output | 1 | A bus cycle is open |
| cyc_write | output | 1 | Direction of the open cycle |
| cyc_addr | output | ADDR_W | Address of the open cycle |
| cyc_size | output | 2 | Outstanding bytes modulo 4 |
| cyc_wdata | output | 32 | Write data on the four lanes |
| bus_ack | input | 2 | Port width acknowledge or wait |
| bus_rdata | input | 32 | Read data on the four lanes |
| done_valid | output | 1 | Access complete (one cycle) |
| done_rdata | output | 32 | Gathered read operand |

## Verification
The assertions assume that `bus_ack` takes meaningful values only while `cyc_valid` is high. They also assume the device acknowledges every open cycle within a bounded number of waits, so each access ends. The bench's device model answers only while a cycle is open and limits wait states to a small per-request count. The requester raises `req_valid` only after the previous done pulse, so it never has to hold a request across a busy sequencer.

// File: rtl/dbs_pkg.sv
package dbs_pkg;
  localparam int LANES = 4;
  localparam int DATA_W = 8 * LANES;

  typedef enum logic [1:0] {
    K_BYTE  = 2'd0,
    K_WORD  = 2'd1,
    K_LONG  = 2'd2,
    K_FETCH = 2'd3
  } kind_e;

  typedef enum logic [1:0] {
    ACK_W32  = 2'd0,
    ACK_W16  = 2'd1,
    ACK_W8   = 2'd2,
    ACK_WAIT = 2'd3
  } ack_e;

  function automatic logic [2:0] kind_bytes(input logic [1:0] k);
    case (k)
      K_BYTE:  return 3'd1;
      K_WORD:  return 3'd2;
      default: return 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/dbs_chunk.sv
module dbs_chunk
  import dbs_pkg::*;
(
  input  logic [1:0] addr_lo,
  input  logic [2:0] remain,
  input  logic [1:0] ack,
  output logic [2:0] take,
  output logic [1:0] start_lane
);
  logic [2:0] room;

  always_comb begin
    case (ack)
      ACK_W32: begin
        room       = 3'd4 - {1'b0, addr_lo};
        start_lane = addr_lo;
      end
      ACK_W16: begin
        room       = 3'd2 - {2'b00, addr_lo[0]};
        start_lane = {1'b0, addr_lo[0]};
      end
      default: begin
        room       = 3'd1;
        start_lane = 2'd0;
      end
    endcase
    take = (remain < room) ? remain : room;
  end
endmodule

// File: rtl/dbs_wr_lanes.sv
module dbs_wr_lanes
  import dbs_pkg::*;
(
  input  logic [1:0]        addr_lo,
  input  logic [DATA_W-1:0] pend,
  output logic [DATA_W-1:0] lanes
);
  for (genvar L = 0; L < LANES; L++) begin : g_lane
    always_comb begin
      int idx;
      if (L >= int'(addr_lo))
        idx = L - int'(addr_lo);
      else if (L < 2 && L >= int'(addr_lo[0]))
        idx = L - int'(addr_lo[0]);
      else
        idx = 0;
      lanes[DATA_W-1-8*L -: 8] = pend[DATA_W-1-8*idx -: 8];
    end
  end
endmodule

// File: rtl/dbs_rd_gather.sv
module dbs_rd_gather
  import dbs_pkg::*;
(
  input  logic [DATA_W-1:0] acc,
  input  logic [DATA_W-1:0] rdata,
  input  logic [1:0]        start_lane,
  input  logic [2:0]        take,
  output logic [DATA_W-1:0] acc_next
);
  logic [DATA_W-1:0] window;
  logic [DATA_W-1:0] piece;
  logic [5:0]        sh_out;

  always_comb begin
    window = rdata << {start_lane, 3'b000};
    sh_out = 6'd32 - {take, 3'b000};
    piece  = window >> sh_out;
    if (take == 3'd4)
      acc_next = piece;
    else
      acc_next = (acc << {take, 3'b000}) | piece;
  end
endmodule

// File: rtl/dbs_sequencer.sv
module dbs_sequencer
  import dbs_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_kind,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              cyc_valid,
  output logic              cyc_write,
  output logic [ADDR_W-1:0] cyc_addr,
  output logic [1:0]        cyc_size,
  output logic [31:0]       cyc_wdata,
  input  logic [1:0]        bus_ack,
  input  logic [31:0]       bus_rdata,
  output logic              done_valid,
  output logic [31:0]       done_rdata
);
  logic              busy_q;
  logic              wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [2:0]        rem_q;
  logic [31:0]       pend_q;
  logic [31:0]       acc_q;
  logic              done_q;
  logic [31:0]       done_data_q;

  logic [2:0]  take;
  logic [1:0]  start_lane;
  logic [31:0] acc_next;
  logic [2:0]  req_n;
  logic        beat;

  assign req_n = kind_bytes(req_kind);
  assign beat  = busy_q && (bus_ack != ACK_WAIT);

  dbs_chunk u_chunk (
    .addr_lo    (addr_q[1:0]),
    .remain     (rem_q),
    .ack        (bus_ack),
    .take       (take),
    .start_lane (start_lane)
  );

  dbs_wr_lanes u_lanes (
    .addr_lo (addr_q[1:0]),
    .pend    (pend_q),
    .lanes   (cyc_wdata)
  );

  dbs_rd_gather u_gather (
    .acc        (acc_q),
    .rdata      (bus_rdata),
    .start_lane (start_lane),
    .take       (take),
    .acc_next   (acc_next)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q      <= 1'b0;
      wr_q        <= 1'b0;
      addr_q      <= '0;
      rem_q       <= '0;
      pend_q      <= '0;
      acc_q       <= '0;
      done_q      <= 1'b0;
      done_data_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (req_valid) begin
          busy_q <= 1'b1;
          wr_q   <= req_write;
          addr_q <= (req_kind == K_FETCH) ? {req_addr[ADDR_W-1:2], 2'b00} : req_addr;
          rem_q  <= req_n;
          pend_q <= req_wdata << (6'd32 - {req_n, 3'b000});
          acc_q  <= '0;
        end
      end else if (beat) begin
        addr_q <= addr_q + ADDR_W'(take);
        rem_q  <= rem_q - take;
        pend_q <= pend_q << {take, 3'b000};
        if (!wr_q) acc_q <= acc_next;
        if (rem_q == take) begin
          busy_q      <= 1'b0;
          done_q      <= 1'b1;
          done_data_q <= wr_q ? 32'd0 : acc_next;
        end
      end
    end
  end

  assign req_ready  = !busy_q;
  assign cyc_valid  = busy_q;
  assign cyc_write  = wr_q;
  assign cyc_addr   = addr_q;
  assign cyc_size   = rem_q[1:0];
  assign done_valid = done_q;
  assign done_rdata = done_data_q;
endmodule

// File: rtl/dbs_sequencer_chk.sv
module dbs_sequencer_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              cyc_valid,
  input logic [ADDR_W-1:0] cyc_addr,
  input logic [1:0]        cyc_size,
  input logic [1:0]        bus_ack,
  input logic              done_valid
);
  p_take_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (cyc_valid && !req_ready));

  p_wait_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && bus_ack == 2'd3) |=>
      (cyc_valid && $stable(cyc_addr) && $stable(cyc_size)));

  p_addr_moves_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && bus_ack != 2'd3) |=>
      (done_valid || (cyc_valid && cyc_addr != $past(cyc_addr))));

  p_done_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> !done_valid);

  p_done_after_ack_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_valid) |-> ($past(cyc_valid) && $past(bus_ack) != 2'd3 && !cyc_valid));
endmodule

bind dbs_sequencer dbs_sequencer_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .cyc_valid  (cyc_valid),
  .cyc_addr   (cyc_addr),
  .cyc_size   (cyc_size),
  .bus_ack    (bus_ack),
  .done_valid (done_valid)
);

// File: tb/dbs_sequencer_test.sv
module dbs_sequencer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_kind = 2'd0;
  logic        req_write = 1'b0;
  logic [31:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        cyc_valid, cyc_write;
  logic [31:0] cyc_addr;
  logic [1:0]  cyc_size;
  logic [31:0] cyc_wdata;
  logic [1:0]  bus_ack = 2'd3;
  logic [31:0] bus_rdata = '0;
  logic        done_valid;
  logic [31:0] done_rdata;

  always #2 clk = ~clk;

  dbs_sequencer #(.ADDR_W(32)) uut (.*);

  typedef struct {bit wr; int cyc; logic [31:0] data; string tag;} item_t;
  item_t sb[$];

  int checks = 0, errors = 0;
  logic [7:0] mem [0:63];
  int pw = 0, waits = 0, wcnt = 0, cyc_cnt = 0, done_seen = 0;
  bit new_txn = 0;
  logic [31:0] first_addr;
  logic [1:0]  first_size;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int exp_cycles(input int kind, input int a, input int p);
    case (kind)
      0: return 1;
      1: if (p == 2) return 2;
         else if (p == 0) return (a == 3) ? 2 : 1;
         else return (a == 0 || a == 2) ? 1 : 2;
      2: if (p == 2) return 4;
         else if (p == 0) return (a == 0) ? 1 : 2;
         else return (a == 1 || a == 3) ? 3 : 2;
      default: return (p == 0) ? 1 : (p == 1) ? 2 : 4;
    endcase
  endfunction

  // device model: answers open cycles with the selected port width
  always @(negedge clk) begin : dev
    int a, room, take, st, n;
    if (cyc_valid) begin
      if (new_txn) begin
        first_addr = cyc_addr;
        first_size = cyc_size;
        new_txn = 0;
      end
      if (wcnt < waits) begin
        bus_ack = 2'd3;
        wcnt++;
      end else begin
        wcnt = 0;
        bus_ack = 2'(pw);
        a = int'(cyc_addr[5:0]);
        n = (cyc_size == 2'd0) ? 4 : int'(cyc_size);
        if (pw == 0) begin room = 4 - (a % 4); st = a % 4; end
        else if (pw == 1) begin room = 2 - (a % 2); st = a % 2; end
        else begin room = 1; st = 0; end
        take = (n < room) ? n : room;
        bus_rdata = 32'hEEEE_EEEE;
        for (int j = 0; j < take; j++) begin
          if (cyc_write) mem[a+j] = cyc_wdata[31-8*(st+j) -: 8];
          else bus_rdata[31-8*(st+j) -: 8] = mem[a+j];
        end
        cyc_cnt++;
      end
    end else begin
      bus_ack = 2'd3;
    end
  end

  // monitor: pops the scoreboard on each done pulse
  always @(negedge clk) begin
    if (rst_n && done_valid) begin
      if (sb.size() == 0) begin
        chk(0, "R11", "unexpected done", 32'd1, 32'd0);
      end else begin
        item_t it;
        it = sb.pop_front();
        chk(cyc_cnt == it.cyc, {"R2/", it.tag}, "bus cycles", cyc_cnt, it.cyc);
        if (!it.wr)
          chk(done_rdata == it.data, "R10", "read operand", done_rdata, it.data);
      end
      cyc_cnt = 0;
      done_seen++;
    end
  end

  task automatic run(input int kind, input int addr, input bit wr,
                     input logic [31:0] wd, input int port, input int nw,
                     input string tag);
    item_t it;
    logic [7:0] shadow [0:63];
    int n, base, ds0;
    n = (kind == 0) ? 1 : (kind == 1) ? 2 : 4;
    base = (kind == 3) ? (addr & ~3) : addr;
    it.wr = wr;
    it.cyc = exp_cycles(kind, base % 4 == 0 ? addr % 4 : addr % 4, port);
    it.tag = tag;
    it.data = '0;
    for (int j = 0; j < n; j++) it.data = (it.data << 8) | 32'(mem[base+j]);
    for (int i = 0; i < 64; i++) shadow[i] = mem[i];
    if (wr) for (int j = 0; j < n; j++) shadow[base+j] = wd[8*(n-1-j) +: 8];
    sb.push_back(it);
    pw = port; waits = nw; wcnt = 0; new_txn = 1;
    ds0 = done_seen;
    @(negedge clk);
    req_valid = 1'b1; req_kind = 2'(kind); req_write = wr;
    req_addr = 32'(addr); req_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R1", "ready while busy", 32'(req_ready), 32'd0);
    while (done_seen == ds0) @(negedge clk);
    chk(first_addr[1:0] == 2'(base), "R6", "first cycle address", first_addr, 32'(base));
    chk(first_size == 2'(n % 4), "R7", "first size code", 32'(first_size), 32'(n % 4));
    if (wr)
      for (int i = base - 1; i <= base + n; i++)
        chk(mem[i] == shadow[i], "R9/R12", "memory byte", 32'(mem[i]), 32'(shadow[i]));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    chk(0, "R11", "watchdog hang", 32'd0, 32'd1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 8'(i * 7 + 3);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "reset ready", 32'(req_ready), 32'd1);
    chk(cyc_valid == 1'b0, "R1", "reset cyc_valid", 32'(cyc_valid), 32'd0);
    chk(done_valid == 1'b0, "R11", "reset done", 32'(done_valid), 32'd0);
    rst_n = 1'b1;
    for (int p = 0; p < 3; p++)
      for (int k = 0; k < 3; k++)
        for (int a = 0; a < 4; a++) begin
          string t;
          t = (k == 0) ? "R3" : (k == 1) ? "R4" : "R5";
          run(k, 16 + 4 * k + a, 0, 32'h0, p, 0, t);
          run(k, 16 + 4 * k + a, 1, 32'hA1B2_C3D4 + 32'(p * 16 + a), p, 0, t);
        end
    for (int p = 0; p < 3; p++) run(3, 8, 0, 32'h0, p, 0, "R6");
    run(3, 13, 0, 32'h0, 0, 0, "R6");
    run(3, 42, 0, 32'h0, 1, 0, "R6");
    run(2, 33, 0, 32'h0, 1, 2, "R8");
    run(1, 39, 1, 32'h5566_7788, 2, 3, "R8");
    run(2, 27, 1, 32'hCAFE_F00D, 0, 1, "R8");
    run(0, 50, 1, 32'hAABB_CCDD, 1, 0, "R12");
    repeat (4) @(negedge clk);
    chk(sb.size() == 0, "R11", "outstanding items", 32'(sb.size()), 32'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule